// File: doc/BRIEF.md
# Parallel ADC Bus Read Controller

This block sits on the host side of a byte-wide parallel analog-to-digital converter and runs one conversion per start request from internal logic. It drives the converter's active-low select, read and write strobes. It watches the converter's completion lines and hands the captured byte and an overflow flag to a consumer through a valid/ready handshake.

Two conversion handshakes are offered, picked per request by `mode_wr_i`. In held-read mode (`mode_wr_i` = 0) one read strobe both starts the conversion and stays low until the result is on the bus. In write-start mode (`mode_wr_i` = 1) a write pulse starts the conversion, and a separate read pulse fetches the result once the interrupt line reports completion. The ready, interrupt and overflow inputs pass through two-flop synchronizers. A conversion that never completes is abandoned after a programmable number of cycles, and an error flag is raised.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset `adc_cs_no`, `adc_rd_no` and `adc_wr_no` are high, and `res_valid_o` and `err_o` are low.
- R2: With `mode_wr_i` = 0 at the start, `adc_rd_no` falls `SETUP_CYC` cycles after `adc_cs_no` falls and stays low until completion, giving one read rising edge per conversion. `adc_wr_no` never goes low.
- R3: With `mode_wr_i` = 1 at the start, `adc_wr_no` is pulsed low for exactly `STROBE_CYC` cycles. After completion `adc_rd_no` is pulsed low for exactly `STROBE_CYC` cycles, and the bus is sampled during that pulse.
- R4: `adc_rd_no` or `adc_wr_no` is low only while `adc_cs_no` is low, and the first strobe falls exactly `SETUP_CYC` cycles after `adc_cs_no` falls.
- R5: Completion is a synchronized low on `adc_int_ni`. In held-read mode it is also a synchronized `adc_rdy_i` that has been seen low and then high again, so a converter with only the ready line completes too.
- R6: The captured `res_data_o` equals `adc_db_i` at capture, with bit 7 as MSB and bit 0 as LSB. `res_ovf_o` is 1 when `adc_ofl_ni` was low at capture. A full-scale overflow therefore reads as data 8'hFF with `res_ovf_o` = 1.
- R7: `res_valid_o` stays high, with data and overflow unchanged, until a cycle with `res_ready_i` high. It falls on the next cycle.
- R8: A start request while `res_valid_o` is high is ignored, and `adc_cs_no` stays high.
- R9: If no completion arrives within `TIMEOUT_CYC` cycles of waiting, all strobes and select are released, `err_o` goes high and no result becomes valid. `err_o` is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| mode_wr_i | input | 1 | 0 = held-read, 1 = write-start then read |
| res_valid_o | output | 1 | Result pending |
| res_ready_i | input | 1 | Consumer accepts the result |
| res_data_o | output | 8 | Captured conversion byte |
| res_ovf_o | output | 1 | Captured overflow flag |
| err_o | output | 1 | Last conversion timed out |
| adc_cs_no | output | 1 | Converter select, active low |
| adc_rd_no | output | 1 | Converter read strobe, active low |
| adc_wr_no | output | 1 | Converter write strobe, active low |
| adc_rdy_i | input | 1 | Open-drain ready line, pulled up externally |
| adc_int_ni | input | 1 | Conversion-complete interrupt, active low |
| adc_ofl_ni | input | 1 | Overflow line, active low, always driven |
| adc_db_i | input | 8 | Converter data bus |

## Verification
A wrong sequencer state shows on the converter strobes within one cycle. Examples are a strobe without select, a setup gap or pulse width off by one, or a write pulse in held-read mode, and a bus monitor counts each of these per cycle. Wrong completion decoding shows either as a premature capture of the idle bus pattern or as a spurious timeout some `TIMEOUT_CYC` cycles later. A broken result holding stage shows as a dropped or changed result during a stalled handshake, or as select falling for a start given while a result is pending.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WR,
    ST_WAIT,
    ST_RD,
    ST_DONE
  } adc_st_e;

  localparam int unsigned SYNC_W = 3;
  localparam int unsigned SYNC_RDY = 0;
  localparam int unsigned SYNC_INT = 1;
  localparam int unsigned SYNC_OFL = 2;
endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq
  import adc_bus_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned STROBE_CYC  = 2,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mode_wr_i,
  input  logic pend_i,
  input  logic rdy_s_i,
  input  logic int_s_ni,
  output logic cs_no,
  output logic rd_no,
  output logic wr_no,
  output logic cap_o,
  output logic err_o
);
  localparam int unsigned CMAX = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int unsigned CW   = (CMAX > 1) ? $clog2(CMAX + 1) : 1;
  localparam int unsigned TW   = $clog2(TIMEOUT_CYC + 1);

  adc_st_e       st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmo;
  logic          mode_q;
  logic          seen_lo;
  logic          done;

  // ready counts only after a low was observed, so a stale high is not a completion
  assign done = !int_s_ni || (!mode_q && seen_lo && rdy_s_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      tmo     <= '0;
      mode_q  <= 1'b0;
      seen_lo <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_i && !pend_i) begin
            mode_q <= mode_wr_i;
            err_o  <= 1'b0;
            cnt    <= CW'(SETUP_CYC - 1);
            st     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            tmo     <= '0;
            seen_lo <= 1'b0;
            if (mode_q) begin
              cnt <= CW'(STROBE_CYC - 1);
              st  <= ST_WR;
            end else begin
              st <= ST_WAIT;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WR: begin
          if (cnt == '0) st <= ST_WAIT;
          else           cnt <= cnt - 1'b1;
        end
        ST_WAIT: begin
          if (!rdy_s_i) seen_lo <= 1'b1;
          if (done) begin
            if (mode_q) begin
              cnt <= CW'(STROBE_CYC - 1);
              st  <= ST_RD;
            end else begin
              st <= ST_DONE;
            end
          end else if (tmo == TW'(TIMEOUT_CYC - 1)) begin
            err_o <= 1'b1;
            st    <= ST_DONE;
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        ST_RD: begin
          if (cnt == '0) st <= ST_DONE;
          else           cnt <= cnt - 1'b1;
        end
        ST_DONE: begin
          // wait for the interrupt to clear so the next request sees no stale completion
          if (int_s_ni) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cs_no = !(st inside {ST_SETUP, ST_WR, ST_WAIT, ST_RD});
  assign rd_no = !((st == ST_WAIT && !mode_q) || st == ST_RD);
  assign wr_no = !(st == ST_WR);
  assign cap_o = (st == ST_WAIT && !mode_q && done) || (st == ST_RD && cnt == '0);

  // R4
  strobe_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !cs_no);
  // R8
  pend_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && pend_i) |=> st == ST_IDLE);
  // R9
  err_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_no && rd_no && wr_no));
  // R9
  tmo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WAIT) |-> (tmo < TW'(TIMEOUT_CYC)));
  // R2
  no_wr_in_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && st != ST_IDLE) |-> wr_no);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ovf_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ovf_o   <= 1'b0;
    end else if (cap_i && !valid_o) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      ovf_o   <= ovf_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(ovf_o)));
  // R7
  result_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i) |=> !valid_o);
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned STROBE_CYC  = 2,
  parameter int unsigned TIMEOUT_CYC = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_wr_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_ovf_o,
  output logic              err_o,
  output logic              adc_cs_no,
  output logic              adc_rd_no,
  output logic              adc_wr_no,
  input  logic              adc_rdy_i,
  input  logic              adc_int_ni,
  input  logic              adc_ofl_ni,
  input  logic [DATA_W-1:0] adc_db_i
);
  logic [SYNC_W-1:0] raw, syn;
  logic              cap;

  assign raw[SYNC_RDY] = adc_rdy_i;
  assign raw[SYNC_INT] = adc_int_ni;
  assign raw[SYNC_OFL] = adc_ofl_ni;

  adc_sync2 #(.W(SYNC_W), .RST_VAL('1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  adc_bus_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_wr_i(mode_wr_i),
    .pend_i   (res_valid_o),
    .rdy_s_i  (syn[SYNC_RDY]),
    .int_s_ni (syn[SYNC_INT]),
    .cs_no    (adc_cs_no),
    .rd_no    (adc_rd_no),
    .wr_no    (adc_wr_no),
    .cap_o    (cap),
    .err_o    (err_o)
  );

  adc_result_hold #(.DATA_W(DATA_W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .data_i (adc_db_i),
    .ovf_i  (!syn[SYNC_OFL]),
    .ready_i(res_ready_i),
    .valid_o(res_valid_o),
    .data_o (res_data_o),
    .ovf_o  (res_ovf_o)
  );

  // R9
  no_result_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !$rose(res_valid_o));
endmodule

// File: tb/adc_bus_ctrl_tb.sv
module adc_bus_ctrl_tb;
  localparam int unsigned SETUP_CYC   = 2;
  localparam int unsigned STROBE_CYC  = 2;
  localparam int unsigned TIMEOUT_CYC = 1000;
  localparam int unsigned CONV_CYC    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_wr = 1'b0, rdy_in = 1'b0;
  logic valid, ovf, err, cs_n, rd_n, wr_n;
  logic [7:0] data;

  // converter model state and controls
  logic m_wrmode = 1'b0, m_dead = 1'b0, m_en_int = 1'b1, m_en_rdy = 1'b1, m_ovf = 1'b0;
  logic [7:0] m_val = 8'h00;
  logic m_rdy, m_int_n, m_ofl_n, m_busy, m_lat, prev_rd, prev_wr;
  logic [7:0] m_cnt;
  logic [7:0] db;

  int n_chk = 0, n_bad = 0;
  int viol = 0, wr_falls = 0, rd_rises = 0, cs_falls = 0;
  int gap = 0, last_gap = 0, wr_w = 0, last_wr_w = 0, rd_w = 0, last_rd_w = 0;
  logic prev_cs = 1'b1, prev_strobe = 1'b0, prev_wr_m = 1'b1, prev_rd_m = 1'b1;

  always #5 clk = ~clk;

  adc_bus_ctrl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_wr_i(mode_wr),
    .res_valid_o(valid), .res_ready_i(rdy_in), .res_data_o(data), .res_ovf_o(ovf),
    .err_o(err), .adc_cs_no(cs_n), .adc_rd_no(rd_n), .adc_wr_no(wr_n),
    .adc_rdy_i(m_rdy), .adc_int_ni(m_int_n), .adc_ofl_ni(m_ofl_n), .adc_db_i(db)
  );

  assign db = (m_lat && !cs_n && !rd_n) ? (m_ovf ? 8'hFF : m_val) : 8'h5A;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_rdy <= 1'b1; m_int_n <= 1'b1; m_ofl_n <= 1'b1; m_busy <= 1'b0;
      m_lat <= 1'b0; m_cnt <= '0; prev_rd <= 1'b1; prev_wr <= 1'b1;
    end else begin
      prev_rd <= rd_n;
      prev_wr <= wr_n;
      if (!m_wrmode && !cs_n && prev_rd && !rd_n && !m_dead) begin
        m_busy <= 1'b1; m_cnt <= 8'(CONV_CYC); m_lat <= 1'b0; m_ofl_n <= 1'b1;
        m_int_n <= 1'b1; m_rdy <= !m_en_rdy;
      end else if (m_wrmode && !cs_n && !prev_wr && wr_n && !m_dead) begin
        m_busy <= 1'b1; m_cnt <= 8'(CONV_CYC); m_lat <= 1'b0; m_ofl_n <= 1'b1;
        m_int_n <= 1'b1;
      end else if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy <= 1'b0; m_lat <= 1'b1; m_rdy <= 1'b1; m_ofl_n <= !m_ovf;
          if (m_en_int) m_int_n <= 1'b0;
        end else begin
          m_cnt <= m_cnt - 1'b1;
        end
      end else if (!prev_rd && rd_n) begin
        m_int_n <= 1'b1;
      end
    end
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if ((!rd_n || !wr_n) && cs_n) viol <= viol + 1;
      if (prev_cs && !cs_n) cs_falls <= cs_falls + 1;
      if (!cs_n && rd_n && wr_n && !prev_strobe) gap <= gap + 1;
      else if (cs_n) gap <= 0;
      if ((!rd_n || !wr_n) && !prev_strobe) last_gap <= gap;
      if (!wr_n) wr_w <= wr_w + 1;
      if (prev_wr_m && !wr_n) wr_falls <= wr_falls + 1;
      if (!prev_wr_m && wr_n) begin last_wr_w <= wr_w; wr_w <= 0; end
      if (!rd_n) rd_w <= rd_w + 1;
      if (!prev_rd_m && rd_n) begin rd_rises <= rd_rises + 1; last_rd_w <= rd_w; rd_w <= 0; end
      prev_cs <= cs_n;
      prev_strobe <= !rd_n || !wr_n || (prev_strobe && !cs_n);
      prev_wr_m <= wr_n;
      prev_rd_m <= rd_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic m);
    @(negedge clk);
    mode_wr = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if (valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic accept();
    @(negedge clk); rdy_in = 1'b1;
    @(negedge clk); rdy_in = 1'b0;
  endtask

  task automatic t_reset();
    chk(cs_n && rd_n && wr_n, "R1 strobes idle", {cs_n, rd_n, wr_n}, 3'b111);
    chk(!valid && !err, "R1 valid/err low", {valid, err}, 0);
  endtask

  task automatic t_read(input logic [7:0] v, input bit use_int, input string tag);
    bit got; int wf0, rr0;
    m_wrmode = 1'b0; m_val = v; m_ovf = 1'b0; m_en_int = use_int; m_en_rdy = 1'b1;
    wf0 = wr_falls; rr0 = rd_rises;
    pulse_start(1'b0);
    wait_valid(got);
    repeat (4) @(negedge clk);
    chk(got && data == v && !ovf, {tag, " data"}, {ovf, data}, v);
    chk(wr_falls == wf0, "R2 no write strobe", wr_falls - wf0, 0);
    chk(rd_rises == rr0 + 1, "R2 single read edge", rd_rises - rr0, 1);
    chk(last_gap == SETUP_CYC, "R4 setup gap read", last_gap, SETUP_CYC);
    accept();
  endtask

  task automatic t_write(input logic [7:0] v);
    bit got; int wf0;
    m_wrmode = 1'b1; m_val = v; m_ovf = 1'b0; m_en_int = 1'b1;
    wf0 = wr_falls;
    pulse_start(1'b1);
    wait_valid(got);
    repeat (4) @(negedge clk);
    chk(got && data == v && !ovf, "R3 write-mode data", {ovf, data}, v);
    chk(wr_falls == wf0 + 1 && last_wr_w == STROBE_CYC, "R3 write width", last_wr_w, STROBE_CYC);
    chk(last_rd_w == STROBE_CYC, "R3 read width", last_rd_w, STROBE_CYC);
    chk(last_gap == SETUP_CYC, "R4 setup gap write", last_gap, SETUP_CYC);
    accept();
  endtask

  task automatic t_overflow();
    bit got;
    m_wrmode = 1'b1; m_val = 8'h12; m_ovf = 1'b1; m_en_int = 1'b1;
    pulse_start(1'b1);
    wait_valid(got);
    chk(got && ovf && data == 8'hFF, "R6 overflow capture", {ovf, data}, 9'h1FF);
    accept();
    m_ovf = 1'b0;
  endtask

  task automatic t_hold_and_ignore();
    bit got; bit stay; int cf0;
    m_wrmode = 1'b0; m_val = 8'hC3; m_en_int = 1'b1;
    pulse_start(1'b0);
    wait_valid(got);
    repeat (6) @(negedge clk);
    cf0 = cs_falls;
    pulse_start(1'b0);
    stay = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!valid || data != 8'hC3) stay = 1'b0;
    end
    chk(got && stay, "R7 result held while stalled", data, 8'hC3);
    chk(cs_falls == cf0 && cs_n, "R8 start ignored while pending", cs_falls - cf0, 0);
    @(negedge clk); rdy_in = 1'b1;
    @(negedge clk); rdy_in = 1'b0;
    chk(!valid, "R7 valid drops after accept", valid, 0);
  endtask

  task automatic t_timeout();
    int n; bit seen;
    m_dead = 1'b1; m_wrmode = 1'b0;
    pulse_start(1'b0);
    n = 0; seen = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      n++;
      if (err) begin seen = 1'b1; break; end
    end
    chk(seen && n >= TIMEOUT_CYC, "R9 timeout raises error", n, TIMEOUT_CYC);
    chk(cs_n && rd_n && wr_n && !valid, "R9 bus released, no result", {cs_n, rd_n, wr_n, valid}, 4'b1110);
    m_dead = 1'b0;
    repeat (8) @(negedge clk);
    pulse_start(1'b0);
    chk(!err, "R9 error cleared by start", err, 0);
    m_val = 8'h77; m_en_int = 1'b1; m_wrmode = 1'b0;
    begin
      bit got;
      wait_valid(got);
      chk(got && data == 8'h77, "R9 recovery conversion", data, 8'h77);
    end
    accept();
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_read(8'h3C, 1'b1, "R2 read-mode int");
    t_read(8'h81, 1'b0, "R5 read-mode ready only");
    t_write(8'hA6);
    t_write(8'h01);
    t_overflow();
    t_hold_and_ignore();
    t_timeout();
    repeat (4) @(negedge clk);
    chk(viol == 0, "R4 strobe without select", viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule